// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register Lock

This block is a watchdog peripheral that sits on a simple APB-style register bus. A down-counter advances on cycles where a tick-enable input is high. When it runs out the first time it raises an interrupt and starts a new period from the programmed reload value. If software has not cleared that interrupt by the time the second period runs out, the block drives a system reset request.

Software keeps the system alive by writing to the clear register. That write drops the pending interrupt and restarts the period. Every register that changes behaviour sits behind a key lock. Writing the key word opens the lock, and writing any other word to the lock register closes it again. A reload value of zero followed by arming both enables gives a near-immediate reset, which software uses as a forced restart.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the lock register (0xC00) reads 1 (locked), control (0x008) reads 0, reload (0x000) and count (0x004) read 0xFFFFFFFF, and both irq_o and sysrst_o are low.
- R2: Writing 0x1ACCE551 to 0xC00 unlocks, so it reads 0. Writing any other word to 0xC00 locks, so it reads 1. Lock writes are always accepted.
- R3: While locked, writes to reload (0x000), control (0x008) and clear (0x00C) have no effect.
- R4: An unlocked write to 0x000 sets the reload value and loads the counter with it in the same cycle. Writes to 0x004 have no effect.
- R5: The counter drops by one on each clock with tick_en high while control bit 0 is set. It holds its value when control bit 0 is clear or tick_en is low.
- R6: A tick with count 0 and no interrupt pending sets the interrupt and reloads the counter. From count c, the first expiry falls on tick c+1.
- R7: A tick with count 0 while the interrupt is pending and control bit 1 is set raises sysrst_o, exactly reload+1 ticks after the first expiry. sysrst_o stays high until rst_n is asserted.
- R8: An unlocked write of any value to 0x00C clears the interrupt and reloads the counter. If it falls in the same cycle as an expiry, the clear wins and no reset is raised.
- R9: Bit 0 of 0x010 shows the interrupt state. Bit 0 of 0x014 and irq_o show the interrupt ANDed with control bit 0.
- R10: With control bit 1 clear, a second expiry reloads the counter and keeps the interrupt pending, but sysrst_o stays low.
- R11: Writing reload 0 and then control 3 gives the interrupt on the first tick and sysrst_o on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the only way to drop sysrst_o |
| tick_en | input | 1 | Counter advance enable |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational from state) |
| irq_o | output | 1 | Masked interrupt |
| sysrst_o | output | 1 | System reset request, sticky |

## Verification
Two functions can land on the same cycle: a keep-alive clear and the expiry tick that would otherwise raise the reset. The bench first sets up a pending interrupt with a zero reload value. It then drives tick_en high during the access phase of the clear write, so both events hit the same clock edge. The result counts as correct only if sysrst_o stays low, the interrupt reads clear, and the count reads the reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 12'hC00;

    localparam logic [BUS_W-1:0] OPEN_KEY = 32'h1ACCE551;

    // bit 0 = irq_en (also runs the counter), bit 1 = rst_en
    typedef struct packed {
        logic rst_en;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  reload_val,
    output ctrl_t             ctrl_q,
    output logic              locked_q,
    output logic              restart,
    output logic              clr
);
    typedef struct packed {
        logic             locked;
        logic [CNT_W-1:0] reload;
        ctrl_t            ctrl;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        restart    = 1'b0;
        clr        = 1'b0;
        reload_val = s_q.reload;
        if (wr_en) begin
            case (addr)
                OFS_KEY: s_d.locked = (wdata != OPEN_KEY);
                OFS_RELOAD: if (!s_q.locked) begin
                    s_d.reload = wdata[CNT_W-1:0];
                    reload_val = wdata[CNT_W-1:0];
                    restart    = 1'b1;
                end
                OFS_CTRL: if (!s_q.locked) s_d.ctrl = ctrl_t'(wdata[1:0]);
                OFS_CLEAR: if (!s_q.locked) begin
                    restart = 1'b1;
                    clr     = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.locked <= 1'b1;
            s_q.reload <= '1;
            s_q.ctrl   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reload_q = s_q.reload;
    assign ctrl_q   = s_q.ctrl;
    assign locked_q = s_q.locked;

    p_locked_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.locked && addr == OFS_RELOAD) |=> $stable(s_q.reload));
    p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && s_q.locked && addr == OFS_CTRL) |=> $stable(s_q.ctrl));
    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_KEY && wdata == OPEN_KEY) |=> !s_q.locked);
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             arm,
    input  logic             restart,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             irq_q,
    output logic             fire_q
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
        logic             fire;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (restart) begin
            // a bus restart (reload write or keep-alive) outranks an expiry
            c_d.count = reload_val;
            if (clr) c_d.irq = 1'b0;
        end else if (run && tick_en) begin
            if (c_q.count == '0) begin
                c_d.count = reload_val;
                if (c_q.irq) begin
                    if (arm) c_d.fire = 1'b1;
                end else begin
                    c_d.irq = 1'b1;
                end
            end else begin
                c_d.count = c_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.count <= '1;
            c_q.irq   <= 1'b0;
            c_q.fire  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_q = c_q.count;
    assign irq_q   = c_q.irq;
    assign fire_q  = c_q.fire;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(c_q.count));
    p_fire_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.fire |=> c_q.fire);
    p_fire_after_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.fire) |-> $past(c_q.irq));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !c_q.irq);
    p_clear_beats_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !c_q.fire) |=> !c_q.fire);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              irq_o,
    output logic              sysrst_o
);
    localparam int PAD_W = BUS_W - CNT_W;

    logic             wr_en;
    logic [CNT_W-1:0] reload_q, reload_val, count_q;
    ctrl_t            ctrl_q;
    logic             locked_q, restart, clr, irq_q, fire_q;

    assign wr_en = psel && penable && pwrite;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(paddr), .wdata(pwdata),
        .reload_q(reload_q), .reload_val(reload_val), .ctrl_q(ctrl_q),
        .locked_q(locked_q), .restart(restart), .clr(clr)
    );

    wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(ctrl_q.irq_en),
        .arm(ctrl_q.rst_en), .restart(restart), .clr(clr),
        .reload_val(reload_val), .count_q(count_q), .irq_q(irq_q), .fire_q(fire_q)
    );

    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_RELOAD: prdata = {{PAD_W{1'b0}}, reload_q};
            OFS_COUNT:  prdata = {{PAD_W{1'b0}}, count_q};
            OFS_CTRL:   prdata = {{(BUS_W-2){1'b0}}, ctrl_q};
            OFS_RAW:    prdata = {{(BUS_W-1){1'b0}}, irq_q};
            OFS_MASKED: prdata = {{(BUS_W-1){1'b0}}, irq_q & ctrl_q.irq_en};
            OFS_KEY:    prdata = {{(BUS_W-1){1'b0}}, locked_q};
            default:    prdata = '0;
        endcase
    end

    assign irq_o    = irq_q & ctrl_q.irq_en;
    assign sysrst_o = fire_q;

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q.irq_en);
    p_rst_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sysrst_o) |-> $past(ctrl_q.rst_en));
endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq_o, sysrst_o;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    localparam logic [31:0] KEY = 32'h1ACCE551;

    always #5 clk = ~clk;

    wdog_two_stage u_wdog_two_stage (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .irq_o(irq_o), .sysrst_o(sysrst_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit tick_in_access = 0);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        if (tick_in_access) tick_en = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        paddr = a; psel = 1'b1; pwrite = 1'b0;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(12'hC00, v); chk("R1 lock", v, 1);
        rd(12'h008, v); chk("R1 ctrl", v, 0);
        rd(12'h000, v); chk("R1 reload", v, 32'hFFFFFFFF);
        rd(12'h004, v); chk("R1 count", v, 32'hFFFFFFFF);
        chk("R1 irq_o", irq_o, 0);
        chk("R1 sysrst_o", sysrst_o, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(12'h000, 32'd5); rd(12'h000, v); chk("R3 locked reload", v, 32'hFFFFFFFF);
        wr(12'h008, 32'd3); rd(12'h008, v); chk("R3 locked ctrl", v, 0);
        wr(12'hC00, KEY);   rd(12'hC00, v); chk("R2 unlock", v, 0);
        wr(12'hC00, 32'd1); rd(12'hC00, v); chk("R2 relock", v, 1);
        wr(12'h008, 32'd1); rd(12'h008, v); chk("R3 relocked ctrl", v, 0);
        // get an interrupt pending, lock, then try to clear it
        wr(12'hC00, KEY); wr(12'h000, 32'd0); wr(12'h008, 32'd1);
        ticks(1);
        wr(12'hC00, 32'h0);
        wr(12'h00C, 32'd0);
        rd(12'h010, v); chk("R3 locked clear", v, 1);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        wr(12'hC00, KEY);
        wr(12'h000, 32'd10);
        rd(12'h004, v); chk("R4 reload loads count", v, 10);
        wr(12'h004, 32'h123); rd(12'h004, v); chk("R4 count read-only", v, 10);
        wr(12'h008, 32'd1);
        ticks(3); rd(12'h004, v); chk("R5 decrement", v, 7);
        wr(12'h008, 32'd0);
        ticks(2); rd(12'h004, v); chk("R5 hold when disabled", v, 7);
        wr(12'h008, 32'd1);
        repeat (4) @(negedge clk);
        rd(12'h004, v); chk("R5 hold without tick", v, 7);
    endtask

    task automatic t_first_expiry();
        logic [31:0] v;
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd3); wr(12'h008, 32'd1);
        ticks(3);
        rd(12'h010, v); chk("R6 no irq before tick c+1", v, 0);
        ticks(1);
        rd(12'h010, v); chk("R6 raw irq", v, 1);
        rd(12'h004, v); chk("R6 reloaded", v, 3);
        rd(12'h014, v); chk("R9 masked", v, 1);
        chk("R9 irq_o", irq_o, 1);
        ticks(4);
        chk("R10 no reset without arm", sysrst_o, 0);
        rd(12'h010, v); chk("R10 irq kept", v, 1);
        rd(12'h004, v); chk("R10 reloaded", v, 3);
        wr(12'h008, 32'd2);
        rd(12'h010, v); chk("R9 raw with mask off", v, 1);
        rd(12'h014, v); chk("R9 masked off", v, 0);
        chk("R9 irq_o off", irq_o, 0);
    endtask

    task automatic t_second_expiry();
        logic [31:0] v;
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd2); wr(12'h008, 32'd3);
        ticks(3);
        rd(12'h010, v); chk("R7 first expiry", v, 1);
        ticks(2);
        chk("R7 not yet", sysrst_o, 0);
        ticks(1);
        chk("R7 reset at reload+1", sysrst_o, 1);
        wr(12'h008, 32'd0); wr(12'h00C, 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 sticky", sysrst_o, 1);
        do_reset();
        chk("R7 cleared by rst_n", sysrst_o, 0);
    endtask

    task automatic t_keepalive();
        logic [31:0] v;
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd5); wr(12'h008, 32'd3);
        ticks(6);
        rd(12'h010, v); chk("R8 pending before clear", v, 1);
        ticks(2);
        wr(12'h00C, 32'hDEAD);
        rd(12'h010, v); chk("R8 clear irq", v, 0);
        rd(12'h004, v); chk("R8 clear reloads", v, 5);
        // collision: clear and an expiry with irq pending on the same edge
        wr(12'h000, 32'd0);
        ticks(1);
        rd(12'h010, v); chk("R8 pending before collision", v, 1);
        wr(12'h00C, 32'd1, 1);
        chk("R8 collision no reset", sysrst_o, 0);
        rd(12'h010, v); chk("R8 collision irq cleared", v, 0);
        rd(12'h004, v); chk("R8 collision count", v, 0);
    endtask

    task automatic t_forced();
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd0); wr(12'h008, 32'd3);
        ticks(1);
        chk("R11 irq after first tick", irq_o, 1);
        chk("R11 no reset yet", sysrst_o, 0);
        ticks(1);
        chk("R11 reset on second tick", sysrst_o, 1);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_count();
        t_first_expiry();
        t_second_expiry();
        t_keepalive();
        t_forced();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule